// File: doc/BRIEF.md
# Boot-Layout Block Map with Write Protection

This block sits between a flash command sequencer and its array. It takes a 16-bit word address and reports which of five unequal erase blocks the address falls in: one boot block of 8K words, two parameter blocks of 4K words each, a small main block of 16K words and a large main block of 32K words. Only the four top address bits take part in the decode. A parameter chooses the layout. With the boot block at the top, the blocks run from the large main block at word 0 up to the boot block at the top of memory. With the boot block at the bottom, the same sequence is mirrored and starts at word 0.

Each block has one stored protect bit. A registered protect request sets the bit of the block that a separate block address selects. A global unprotect request runs a fixed sequence, and the sequencer is driven by a state machine. In state IDLE the bits hold or take a protect request. An unprotect request moves the machine IDLE -> FILL. FILL always moves to WIPE, and WIPE always returns to IDLE. The bits become all ones on leaving FILL and all zeros on leaving WIPE, so every block is protected before any bit is cleared.

A temporary-unprotect level lets program and erase reach protected blocks without touching the stored bits. The allow flag depends only on the current inputs and the stored bits. A protection query returns a status byte for the block selected by the block address.

Top module: `prot_block_map`

## Requirements
- R1: With TOP_BOOT=1, `blk_idx_o` (blocks numbered in ascending address order) is 0 for 0000h-7FFFh, 1 for 8000h-BFFFh, 2 for C000h-CFFFh, 3 for D000h-DFFFh and 4 for E000h-FFFFh.
- R2: With TOP_BOOT=0, `blk_idx_o` is 0 for 0000h-1FFFh, 1 for 2000h-2FFFh, 2 for 3000h-3FFFh, 3 for 4000h-7FFFh and 4 for 8000h-FFFFh.
- R3: After reset, every protect bit equals PROT_INIT (default all zero). With the default, every query returns 00h and `allow_o` is 1 at every address.
- R4: When `prot_req_i` is high in IDLE (and `unprot_req_i` is low), the protect bit of the block holding `prot_addr_i` is set at the next rising edge. The other bits do not change.
- R5: While `query_i` is high, `status_o` is 01h if the block holding `prot_addr_i` is protected and 00h if it is not. While `query_i` is low, `status_o` is 00h.
- R6: While `temp_unprot_i` is low, `allow_o` is 0 for an address in a protected block and 1 for an address in an unprotected block. A program or erase is attempted only when `allow_o` is 1.
- R7: While `temp_unprot_i` is high, `allow_o` is 1 at every address and queries still report the stored bits. Once it goes low, previously protected blocks give `allow_o`=0 again.
- R8: An unprotect request in IDLE takes the machine through FILL and WIPE. All bits are ones after the second edge and all bits are zeros after the third edge, and the machine is then back in IDLE.
- R9: Protect and unprotect requests seen in FILL or WIPE are ignored.
- R10: If protect and unprotect requests arrive together in IDLE, the unprotect request wins and the protect request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_addr_i | input | 16 | Word address of a program or erase attempt |
| blk_idx_o | output | 3 | Index of the block holding `op_addr_i` |
| allow_o | output | 1 | High when a program or erase at `op_addr_i` may proceed |
| prot_addr_i | input | 16 | Address choosing the block for protect and query |
| prot_req_i | input | 1 | Protect the block at `prot_addr_i` |
| unprot_req_i | input | 1 | Start the global unprotect sequence |
| temp_unprot_i | input | 1 | Temporary-unprotect level |
| query_i | input | 1 | Protection-status query enable |
| status_o | output | 8 | Protection status byte |

## Verification
If a protect bit holds the wrong value, both `status_o` and `allow_o` show it in the same cycle that the affected block is queried or addressed. A wrong bit is therefore visible one edge after a bad update. A wrong state-machine state shows up in the bits one or two edges later: it may skip the all-ones step, leave bits set after WIPE, or accept a request in FILL or WIPE. To catch these, the bench queries a chosen block after each individual edge of the sequence. A decode error shows at `blk_idx_o` with no delay, so the bench probes both ends of every block in both layouts.

// File: rtl/blkmap_pkg.sv
package blkmap_pkg;
    localparam int NUM_BLK = 5;
    localparam int IDX_W   = $clog2(NUM_BLK);

    typedef logic [IDX_W-1:0] blk_idx_t;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_FILL = 2'd1,
        PS_WIPE = 2'd2
    } prot_state_t;
endpackage

// File: rtl/blkmap_decode.sv
module blkmap_decode
    import blkmap_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int PAGE_W   = 4,
    parameter bit TOP_BOOT = 1'b1,
    parameter int BOOT_PG  = 2,
    parameter int PARAM_PG = 1,
    parameter int MAINS_PG = 4,
    parameter int MAINL_PG = 8
) (
    input  logic [ADDR_W-1:0]  addr_i,
    output blk_idx_t           idx_o,
    output logic [NUM_BLK-1:0] sel_o
);
    // size in pages of the block at ascending position k
    function automatic int size_of(input int k);
        int s;
        case (k)
            0: s = TOP_BOOT ? MAINL_PG : BOOT_PG;
            1: s = TOP_BOOT ? MAINS_PG : PARAM_PG;
            2: s = PARAM_PG;
            3: s = TOP_BOOT ? PARAM_PG : MAINS_PG;
            default: s = TOP_BOOT ? BOOT_PG : MAINL_PG;
        endcase
        return s;
    endfunction

    function automatic int base_of(input int k);
        int b;
        b = 0;
        for (int j = 0; j < k; j++) b += size_of(j);
        return b;
    endfunction

    localparam int PAGE_CNT = 1 << PAGE_W;

    logic [PAGE_W-1:0]  page;
    logic [NUM_BLK-2:0] above;

    assign page = addr_i[ADDR_W-1 -: PAGE_W];

    generate
        for (genvar k = 1; k < NUM_BLK; k++) begin : g_bound
            localparam int BASE = base_of(k);
            assign above[k-1] = (BASE < PAGE_CNT) && (int'(page) >= BASE);
        end
    endgenerate

    always_comb begin
        idx_o = '0;
        for (int k = 0; k < NUM_BLK - 1; k++) begin
            if (above[k]) idx_o = blk_idx_t'(k + 1);
        end
    end

    generate
        for (genvar k = 0; k < NUM_BLK; k++) begin : g_sel
            assign sel_o[k] = (idx_o == blk_idx_t'(k));
        end
    endgenerate
endmodule

// File: rtl/blkmap_prot_fsm.sv
module blkmap_prot_fsm
    import blkmap_pkg::*;
#(
    parameter logic [NUM_BLK-1:0] PROT_INIT = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prot_req_i,
    input  logic [NUM_BLK-1:0] prot_sel_i,
    input  logic               unprot_req_i,
    output logic [NUM_BLK-1:0] prot_o
);
    prot_state_t        state_q, state_d;
    logic [NUM_BLK-1:0] prot_q, prot_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            prot_q  <= PROT_INIT;
        end else begin
            state_q <= state_d;
            prot_q  <= prot_d;
        end
    end

    // next state and bit updates
    always_comb begin
        state_d = state_q;
        prot_d  = prot_q;
        unique case (state_q)
            PS_IDLE: begin
                if (unprot_req_i) begin
                    state_d = PS_FILL;
                end else if (prot_req_i) begin
                    prot_d = prot_q | prot_sel_i;
                end
            end
            PS_FILL: begin
                prot_d  = '1;
                state_d = PS_WIPE;
            end
            PS_WIPE: begin
                prot_d  = '0;
                state_d = PS_IDLE;
            end
            default: begin
                state_d = PS_IDLE;
            end
        endcase
    end

    assign prot_o = prot_q;

    p_protect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_IDLE && prot_req_i && !unprot_req_i)
        |=> ((prot_q & $past(prot_sel_i)) == $past(prot_sel_i)));

    p_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_FILL) |=> (&prot_q));

    p_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_WIPE) |=> (prot_q == '0 && state_q == PS_IDLE));

    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_FILL) |=> (state_q == PS_WIPE));

    p_unprot_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_IDLE && unprot_req_i) |=> $stable(prot_q));
endmodule

// File: rtl/prot_block_map.sv
module prot_block_map
    import blkmap_pkg::*;
#(
    parameter int                 ADDR_W    = 16,
    parameter int                 PAGE_W    = 4,
    parameter bit                 TOP_BOOT  = 1'b1,
    parameter int                 BOOT_PG   = 2,
    parameter int                 PARAM_PG  = 1,
    parameter int                 MAINS_PG  = 4,
    parameter int                 MAINL_PG  = 8,
    parameter logic [NUM_BLK-1:0] PROT_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] op_addr_i,
    output logic [IDX_W-1:0]  blk_idx_o,
    output logic              allow_o,
    input  logic [ADDR_W-1:0] prot_addr_i,
    input  logic              prot_req_i,
    input  logic              unprot_req_i,
    input  logic              temp_unprot_i,
    input  logic              query_i,
    output logic [7:0]        status_o
);
    blk_idx_t           op_idx, q_idx;
    logic [NUM_BLK-1:0] op_sel, q_sel, prot;

    blkmap_decode #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .TOP_BOOT(TOP_BOOT),
        .BOOT_PG(BOOT_PG), .PARAM_PG(PARAM_PG),
        .MAINS_PG(MAINS_PG), .MAINL_PG(MAINL_PG)
    ) u_op_dec (
        .addr_i(op_addr_i), .idx_o(op_idx), .sel_o(op_sel)
    );

    blkmap_decode #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .TOP_BOOT(TOP_BOOT),
        .BOOT_PG(BOOT_PG), .PARAM_PG(PARAM_PG),
        .MAINS_PG(MAINS_PG), .MAINL_PG(MAINL_PG)
    ) u_q_dec (
        .addr_i(prot_addr_i), .idx_o(q_idx), .sel_o(q_sel)
    );

    blkmap_prot_fsm #(.PROT_INIT(PROT_INIT)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .prot_req_i(prot_req_i), .prot_sel_i(q_sel),
        .unprot_req_i(unprot_req_i), .prot_o(prot)
    );

    logic op_hit, q_hit;
    assign op_hit = |(prot & op_sel);
    assign q_hit  = |(prot & q_sel);

    always_comb begin
        blk_idx_o = op_idx;
        allow_o   = !op_hit || temp_unprot_i;
        status_o  = (query_i && q_hit) ? 8'h01 : 8'h00;
    end

    p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_idx_o < IDX_W'(NUM_BLK)) && $onehot(op_sel));

    p_temp_allow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        temp_unprot_i |-> allow_o);

    p_status_fmt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[7:1] == 7'd0) && (!query_i -> status_o == 8'h00));
endmodule

// File: tb/sim_prot_block_map.sv
module sim_prot_block_map;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_addr = '0, prot_addr = '0;
    logic        prot_req = 1'b0, unprot_req = 1'b0, temp = 1'b0, query = 1'b0;
    logic [2:0]  idx0, idx1;
    logic        allow0, allow1;
    logic [7:0]  stat0, stat1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prot_block_map #(.TOP_BOOT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .op_addr_i(op_addr), .blk_idx_o(idx0),
        .allow_o(allow0), .prot_addr_i(prot_addr), .prot_req_i(prot_req),
        .unprot_req_i(unprot_req), .temp_unprot_i(temp), .query_i(query),
        .status_o(stat0)
    );

    prot_block_map #(.TOP_BOOT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .op_addr_i(op_addr), .blk_idx_o(idx1),
        .allow_o(allow1), .prot_addr_i(prot_addr), .prot_req_i(1'b0),
        .unprot_req_i(1'b0), .temp_unprot_i(1'b0), .query_i(1'b0),
        .status_o(stat1)
    );

    logic [15:0] top_lo [5] = '{16'h0000, 16'h8000, 16'hC000, 16'hD000, 16'hE000};
    logic [15:0] top_hi [5] = '{16'h7FFF, 16'hBFFF, 16'hCFFF, 16'hDFFF, 16'hFFFF};
    logic [15:0] bot_lo [5] = '{16'h0000, 16'h2000, 16'h3000, 16'h4000, 16'h8000};
    logic [15:0] bot_hi [5] = '{16'h1FFF, 16'h2FFF, 16'h3FFF, 16'h7FFF, 16'hFFFF};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic query_blk(input string req, input logic [15:0] a, input int exp);
        prot_addr = a;
        query = 1'b1;
        #1;
        chk(req, int'(stat0), exp);
        query = 1'b0;
    endtask

    task automatic protect(input logic [15:0] a);
        @(negedge clk);
        prot_addr = a;
        prot_req = 1'b1;
        @(negedge clk);
        prot_req = 1'b0;
    endtask

    task automatic unprotect_all();
        @(negedge clk);
        unprot_req = 1'b1;
        @(negedge clk);
        unprot_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        for (int k = 0; k < 5; k++) begin
            query_blk("R3 reset status", top_lo[k], 8'h00);
            op_addr = top_hi[k];
            #1;
            chk("R3 reset allow", int'(allow0), 1);
        end
    endtask

    task automatic t_map();
        for (int k = 0; k < 5; k++) begin
            op_addr = top_lo[k]; #1; chk("R1 top low end", int'(idx0), k);
            op_addr = top_hi[k]; #1; chk("R1 top high end", int'(idx0), k);
            op_addr = bot_lo[k]; #1; chk("R2 bottom low end", int'(idx1), k);
            op_addr = bot_hi[k]; #1; chk("R2 bottom high end", int'(idx1), k);
        end
    endtask

    task automatic t_protect();
        protect(16'hE123);
        query_blk("R4 target set", 16'hE000, 8'h01);
        query_blk("R4 neighbour clear", 16'hD000, 8'h00);
        query_blk("R4 other clear", 16'h0000, 8'h00);
        prot_addr = 16'hE000;
        query = 1'b0;
        #1;
        chk("R5 no query gives 00", int'(stat0), 8'h00);
        op_addr = 16'hFFFF; #1; chk("R6 protected denies", int'(allow0), 0);
        op_addr = 16'hDFFF; #1; chk("R6 unprotected allows", int'(allow0), 1);
    endtask

    task automatic t_temp();
        op_addr = 16'hE000;
        temp = 1'b1;
        #1;
        chk("R7 temp allows", int'(allow0), 1);
        query_blk("R7 bit kept during temp", 16'hE000, 8'h01);
        @(negedge clk);
        temp = 1'b0;
        #1;
        chk("R7 reprotected after temp", int'(allow0), 0);
    endtask

    task automatic t_unprot();
        @(negedge clk);
        unprot_req = 1'b1;
        @(negedge clk);
        unprot_req = 1'b0;
        query_blk("R8 after first edge unchanged", 16'h8000, 8'h00);
        @(negedge clk);
        query_blk("R8 all protected after FILL", 16'h8000, 8'h01);
        @(negedge clk);
        for (int k = 0; k < 5; k++)
            query_blk("R8 all cleared after WIPE", top_lo[k], 8'h00);
    endtask

    task automatic t_busy_ignore();
        @(negedge clk);
        unprot_req = 1'b1;
        @(negedge clk);
        unprot_req = 1'b0;
        @(negedge clk);
        prot_addr = 16'hC000;
        prot_req = 1'b1;
        @(negedge clk);
        prot_req = 1'b0;
        query_blk("R9 request in WIPE ignored", 16'hC000, 8'h00);
        op_addr = 16'hC000; #1;
        chk("R9 allow after ignored request", int'(allow0), 1);
    endtask

    task automatic t_priority();
        @(negedge clk);
        prot_addr = 16'h8000;
        prot_req = 1'b1;
        unprot_req = 1'b1;
        @(negedge clk);
        prot_req = 1'b0;
        unprot_req = 1'b0;
        query_blk("R10 protect dropped", 16'h8000, 8'h00);
        @(negedge clk);
        @(negedge clk);
        query_blk("R10 sequence completes", 16'h8000, 8'h00);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_protect();
        t_temp();
        t_unprot();
        t_busy_ignore();
        t_priority();
        protect(16'h0000);
        unprotect_all();
        query_blk("R8 repeat sequence clears", 16'h0000, 8'h00);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule